// File: doc/BRIEF.md
# Quad Special-Wakeup Register Unit

This unit holds the wakeup requests for a group of four cores. It sits on a 64-bit, word-addressed register bus. Software sends a request with a single write. The written data carries only the set or clear value. The cores to update are chosen by a one-hot nibble placed in the register address. The unit keeps one wakeup level per core and drives these levels straight out to the cores. It also keeps one shared done flag, which software reads back from a status register.

Power sequencing is not modelled. A request counts as complete as soon as it is written, so the done flag follows the most recent request value. Any access to an offset the unit does not implement returns all ones and raises a one-cycle flag.

The bus accepts one access per cycle. Every result is registered. Read data and the unimplemented flag appear one cycle after the access, and each read returns the state as it stood before that cycle.

Top module: `qwake_unit`

## Requirements
- R1: After reset every wakeup level is 0, the done flag is 0, and `rd_valid` and `unimp_hit` are 0.
- R2: The word offset is the byte address shifted right by three, so address bits [2:0] have no effect. The request register is at word offset 0x83C and the status register at word offset 0x82C.
- R3: Decode ignores word-offset bits [15:12] (LSB-first numbering). Any value of these bits reaches the same register.
- R4: A write to the request register stores data bit 63 (the most significant bit) as the done flag.
- R5: On a request write, core i takes data bit 63 as its new wakeup level when word-offset bit (15 - i) is 1. Offset bit 15 selects core 0 and offset bit 12 selects core 3. A core that is not selected keeps its level.
- R6: A request write whose select nibble is zero updates the done flag and leaves every core level unchanged.
- R7: A status read returns a word whose only set bits are bits 62 and 59, and only when the done flag is 1. When done is 0 it returns zero.
- R8: A read of any offset other than the status register returns all ones and pulses `unimp_hit`. This includes the request register. The read changes no state.
- R9: A write to any offset other than the request register pulses `unimp_hit` and changes no state. This includes the status register.
- R10: `rd_valid` is high for exactly the one cycle after each read. A write never raises it. `rd_data` reflects the state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 64 | Write data; only bit 63 is used |
| rd_valid | output | 1 | Read response strobe, one cycle after the read |
| rd_data | output | 64 | Read response data |
| unimp_hit | output | 1 | Pulses one cycle after an access to an unimplemented offset |
| core_wake | output | 4 | Wakeup level for each core; bit i is core i |

## Verification
The hardest case to reach is a partial update. The select nibble must change some cores, leave others alone, and update the shared done flag independently of them. The stimulus first builds a mixed pattern of levels with several one-hot and multi-hot nibbles. It then sends a zero nibble that clears done while the levels stay set. After that, a single-core clear must leave every neighbour untouched. Status reads are also sent with a non-zero nibble and with non-zero low address bits, to show the decode mask works. Writes to the status register and reads of the request register confirm that neither direction aliases onto the other.

// File: rtl/qwake_pkg.sv
package qwake_pkg;

    // Classification of the access presented on the register bus
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_REQ   = 2'd1,
        ACC_STAT  = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    // Word offsets of the two implemented registers
    localparam logic [31:0] REQ_WORD_OFF  = 32'h0000_083C;
    localparam logic [31:0] STAT_WORD_OFF = 32'h0000_082C;

    // Done indication positions, counted from the MSB of the data word
    localparam int unsigned DONE_POS_A_MSB = 1;
    localparam int unsigned DONE_POS_B_MSB = 4;

endpackage

// File: rtl/qwake_decode.sv
module qwake_decode
    import qwake_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned SEL_LSB   = 12
) (
    input  logic                 valid,
    input  logic [ADDR_W-1:0]    addr,
    output acc_kind_e            kind,
    output logic [NUM_CORES-1:0] sel
);
    localparam int unsigned OFF_W  = ADDR_W - 3;
    localparam int unsigned SEL_HI = SEL_LSB + NUM_CORES - 1;
    localparam logic [OFF_W-1:0] SEL_FIELD =
        {{(OFF_W-NUM_CORES){1'b0}}, {NUM_CORES{1'b1}}} << SEL_LSB;
    localparam logic [OFF_W-1:0] REQ_OFF  = REQ_WORD_OFF[OFF_W-1:0];
    localparam logic [OFF_W-1:0] STAT_OFF = STAT_WORD_OFF[OFF_W-1:0];

    logic [OFF_W-1:0] word_off;
    logic [OFF_W-1:0] reg_off;
    logic             unused_byte_lanes;

    assign word_off          = addr[ADDR_W-1:3];
    assign unused_byte_lanes = ^addr[2:0];
    assign reg_off           = word_off & ~SEL_FIELD;

    // Core i is picked by the i-th nibble bit counted from its top end
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
        assign sel[i] = word_off[SEL_HI - i];
    end

    always_comb begin
        if (!valid) begin
            kind = ACC_NONE;
        end else if (reg_off == REQ_OFF) begin
            kind = ACC_REQ;
        end else if (reg_off == STAT_OFF) begin
            kind = ACC_STAT;
        end else begin
            kind = ACC_OTHER;
        end
    end

    // R3: the nibble never turns a hit into a miss
    always_comb begin
        if (valid && ((word_off & ~SEL_FIELD) == STAT_OFF)) begin
            assert_stat_nibble_R3: assert (kind == ACC_STAT);
        end
    end

endmodule

// File: rtl/qwake_state.sv
module qwake_state #(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_wr,
    input  logic [NUM_CORES-1:0] req_sel,
    input  logic                 req_val,
    output logic [NUM_CORES-1:0] wake,
    output logic                 done
);
    typedef struct packed {
        logic                 done;
        logic [NUM_CORES-1:0] wake;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_wr) begin
            st_d.done = req_val;
            for (int i = 0; i < NUM_CORES; i++) begin
                if (req_sel[i]) begin
                    st_d.wake[i] = req_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake = st_q.wake;
    assign done = st_q.done;

    // R4: done follows the written value
    assert_done_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> (done == $past(req_val)));

    // R5: an unselected core keeps its level across a request
    assert_unsel_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> ((wake & ~$past(req_sel)) == ($past(wake) & ~$past(req_sel))));

    // R6: a zero select leaves the levels alone
    assert_zero_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && (req_sel == '0)) |=> $stable(wake));

    // R9: nothing changes without a request write
    assert_no_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |=> ($stable(wake) && $stable(done)));

endmodule

// File: rtl/qwake_resp.sv
module qwake_resp
    import qwake_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_write,
    input  acc_kind_e         kind,
    input  logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              unimp
);
    localparam int unsigned POS_A = DATA_W - 1 - DONE_POS_A_MSB;
    localparam int unsigned POS_B = DATA_W - 1 - DONE_POS_B_MSB;
    localparam logic [DATA_W-1:0] DONE_WORD =
        (DATA_W'(1) << POS_A) | (DATA_W'(1) << POS_B);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              unimp;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic is_read;
    logic is_miss;

    always_comb begin
        is_read = (kind != ACC_NONE) && !is_write;
        is_miss = 1'b0;
        if (kind == ACC_OTHER) begin
            is_miss = 1'b1;
        end
        if (kind == ACC_REQ && !is_write) begin
            is_miss = 1'b1;
        end
        if (kind == ACC_STAT && is_write) begin
            is_miss = 1'b1;
        end

        rsp_d       = '0;
        rsp_d.valid = is_read;
        rsp_d.unimp = is_miss;
        if (is_read) begin
            if (kind == ACC_STAT) begin
                rsp_d.data = done ? DONE_WORD : '0;
            end else begin
                rsp_d.data = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.valid;
    assign rd_data  = rsp_q.data;
    assign unimp    = rsp_q.unimp;

    // R10: one response per read, none for writes
    assert_read_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind != ACC_NONE) && !is_write) |=> rd_valid);
    assert_write_no_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == ACC_NONE) || is_write) |=> !rd_valid);

    // R8: a miss read returns all ones
    assert_miss_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_OTHER && !is_write) |=> (unimp && (rd_data == '1)));

    // R7: a status read sees the done flag of the cycle before
    assert_status_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_STAT && !is_write) |=>
            (rd_data == ($past(done) ? DONE_WORD : '0)));

endmodule

// File: rtl/qwake_unit.sv
module qwake_unit
    import qwake_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned SEL_LSB   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 unimp_hit,
    output logic [NUM_CORES-1:0] core_wake
);
    acc_kind_e            kind;
    logic [NUM_CORES-1:0] sel;
    logic                 req_wr;
    logic                 done;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-2:0];

    qwake_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CORES(NUM_CORES),
        .SEL_LSB  (SEL_LSB)
    ) u_decode (
        .valid(bus_valid),
        .addr (bus_addr),
        .kind (kind),
        .sel  (sel)
    );

    assign req_wr = (kind == ACC_REQ) && bus_write;

    qwake_state #(
        .NUM_CORES(NUM_CORES)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_wr (req_wr),
        .req_sel(sel),
        .req_val(bus_wdata[DATA_W-1]),
        .wake   (core_wake),
        .done   (done)
    );

    qwake_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .is_write(bus_write),
        .kind    (kind),
        .done    (done),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .unimp   (unimp_hit)
    );

    // R9: a write that misses the request register is flagged
    assert_bad_write_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (kind != ACC_REQ)) |=> unimp_hit);

endmodule

// File: tb/qwake_unit_test.sv
module qwake_unit_test;
    localparam logic [63:0] ONES     = '1;
    localparam logic [63:0] DONE_WRD = 64'h4800_0000_0000_0000;
    localparam logic [28:0] OFF_REQ  = 29'h83C;
    localparam logic [28:0] OFF_STAT = 29'h82C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        unimp_hit;
    logic [3:0]  core_wake;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_wake = '0;
    logic       exp_done = 1'b0;
    logic        s_rdv;
    logic [63:0] s_rdd;
    logic        s_unimp;

    always #2.5 clk = ~clk;

    qwake_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .unimp_hit(unimp_hit), .core_wake(core_wake)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; outputs sampled on the following negative edge
    task automatic access(logic wr, logic [28:0] off, logic [3:0] nib,
                          logic [2:0] low, logic [63:0] data);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = {off | (29'(nib) << 12), low};
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        s_rdv   = rd_valid;
        s_rdd   = rd_data;
        s_unimp = unimp_hit;
    endtask

    // Bench model of a request write
    task automatic req_write(logic [3:0] nib, logic [63:0] data, logic [2:0] low);
        access(1'b1, OFF_REQ, nib, low, data);
        exp_done = data[63];
        for (int i = 0; i < 4; i++) begin
            if (nib[3-i]) exp_wake[i] = data[63];
        end
        check("R10 write gives no rd_valid", 64'(s_rdv), 64'd0);
        check("R9 request write not flagged", 64'(s_unimp), 64'd0);
        check("R5 core levels", 64'(core_wake), 64'(exp_wake));
    endtask

    task automatic status_read(string tag, logic [3:0] nib, logic [2:0] low);
        access(1'b0, OFF_STAT, nib, low, '0);
        check({tag, " rd_valid"}, 64'(s_rdv), 64'd1);
        check({tag, " status word"}, s_rdd, exp_done ? DONE_WRD : 64'd0);
        check({tag, " no flag"}, 64'(s_unimp), 64'd0);
    endtask

    task automatic t_reset;
        check("R1 wake after reset", 64'(core_wake), 64'd0);
        check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        check("R1 unimp after reset", 64'(unimp_hit), 64'd0);
        status_read("R1 R7 done clear", 4'h0, 3'd0);
    endtask

    task automatic t_select;
        req_write(4'b1000, 64'h8000_0000_0000_0000, 3'd0);
        check("R5 core0 via bit15", 64'(core_wake), 64'h1);
        status_read("R3 R7 nibble on status", 4'hF, 3'd0);
        req_write(4'b0110, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
        check("R5 multi-hot", 64'(core_wake), 64'h7);
        req_write(4'b0001, 64'h8000_0000_0000_0000, 3'd5);
        check("R2 low bits ignored core3", 64'(core_wake), 64'hF);
    endtask

    task automatic t_zero_sel;
        req_write(4'b0000, 64'h7FFF_FFFF_FFFF_FFFF, 3'd0);
        check("R6 levels kept", 64'(core_wake), 64'hF);
        status_read("R4 R6 done cleared", 4'h0, 3'd0);
        req_write(4'b0100, 64'h0, 3'd0);
        check("R5 only core1 cleared", 64'(core_wake), 64'hD);
        req_write(4'b0000, 64'h8000_0000_0000_0000, 3'd0);
        status_read("R4 done set again", 4'h6, 3'd7);
        check("R6 levels after zero set", 64'(core_wake), 64'hD);
    endtask

    task automatic t_misses;
        access(1'b0, OFF_REQ, 4'h0, 3'd0, '0);
        check("R8 request read ones", s_rdd, ONES);
        check("R8 request read flag", 64'(s_unimp), 64'd1);
        check("R10 miss read valid", 64'(s_rdv), 64'd1);
        access(1'b0, 29'h123, 4'h0, 3'd0, '0);
        check("R8 other read ones", s_rdd, ONES);
        check("R8 other read flag", 64'(s_unimp), 64'd1);
        access(1'b1, 29'h500, 4'hF, 3'd0, '0);
        check("R9 other write flag", 64'(s_unimp), 64'd1);
        check("R9 other write wake", 64'(core_wake), 64'(exp_wake));
        access(1'b1, OFF_STAT, 4'hF, 3'd0, '0);
        check("R9 status write flag", 64'(s_unimp), 64'd1);
        check("R9 status write no rd_valid", 64'(s_rdv), 64'd0);
        check("R9 status write wake", 64'(core_wake), 64'(exp_wake));
        status_read("R9 done survives", 4'h0, 3'd0);
        @(negedge clk);
        check("R10 rd_valid single cycle", 64'(rd_valid), 64'd0);
        check("R8 flag single cycle", 64'(unimp_hit), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_zero_sel();
        t_misses();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule